// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block is the device-side column access unit of a synchronous DRAM. It accepts READ and WRITE commands, each with a starting column. For every burst it steps through the column addresses. It returns read words after a CAS latency of two, and it stores write words into a small internal register array. The memory itself is a register array with one word per column, cleared at reset.

A registered clock-enable input lets the controller freeze the block in the middle of a burst. While a burst or a read pipeline is in flight, a low clock-enable sampled on one edge suspends the following internal edge. On a suspended edge the burst counter stays where it is, the read output holds its word, and the command, column and write data inputs are ignored. When the block is idle, a low clock-enable has no effect.

A single-write mode input limits every WRITE to one column. READs still use the programmed burst length. The burst length code and the mode input are static configuration for the duration of a burst.

Top module: `sdram_col_engine`

## Requirements
- R1: After reset `rdata_vld_o` is low and every array column reads back as zero.
- R2: A READ accepted on an internal edge delivers its first word after the second following internal edge, then one word per internal edge, for 1, 2, 4 or 8 words when `bl_code_i` is 0, 1, 2 or 3. `rdata_vld_o` is high exactly while a word is presented.
- R3: Burst columns follow sequential order and wrap within the aligned block of the burst length: the next column keeps the upper bits and increments the low log2(BL) bits modulo BL.
- R4: A WRITE stores `wdata_i` from its command edge at the start column, then the value present on each following internal edge at the next column in R3 order, for BL words in total.
- R5: With `single_wr_i` = 1 a WRITE stores exactly one word, at its start column, and leaves every other column unchanged.
- R6: With `single_wr_i` = 1, READs return the full programmed burst length and order.
- R7: While a burst or read pipeline is active, a clock edge that samples `cke_i` low suspends the next internal edge, and the burst does not advance on that edge.
- R8: Command, column and write data present on a suspended edge are ignored: no array column changes and no new burst starts.
- R9: During a suspended edge `rdata_o` and `rdata_vld_o` keep their values.
- R10: Each suspended edge inside the CAS-latency window delays the first read word by one clock.
- R11: A low `cke_i` sampled while the block is idle is ignored: a command on the next edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable, registered; low suspends the next internal edge during a burst |
| cmd_i | input | 2 | Command: 00 or 11 NOP, 01 READ, 10 WRITE |
| col_i | input | COL_W | Start column for READ/WRITE |
| wdata_i | input | DQ_W | Write data |
| bl_code_i | input | 2 | Burst length code, BL = 1 << code |
| single_wr_i | input | 1 | 1: every WRITE stores one column |
| rdata_o | output | DQ_W | Read data |
| rdata_vld_o | output | 1 | Read data valid |

## Verification
The assertions assume that `bl_code_i` and `single_wr_i` stay constant while a burst is in flight. They also assume that no READ or WRITE is issued on an enabled internal edge before the previous burst and its read pipeline have drained, since a command that overlaps a burst replaces it. The stimulus changes the configuration only between operations. It issues commands on enabled edges only once the bench's model sees the block idle. Extra READ or WRITE commands are driven on purpose only on edges that the model predicts to be suspended.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_NOP_X = 2'b11
  } cmd_e;

  localparam int unsigned BL_CODE_W = 2;
  localparam int unsigned MAX_BL    = 8;
  localparam int unsigned LEN_W     = $clog2(MAX_BL) + 1;

  function automatic logic [LEN_W-1:0] bl_words(input logic [BL_CODE_W-1:0] code);
    return LEN_W'(1) << code;
  endfunction
endpackage

// File: rtl/sdram_col_ctr.sv
module sdram_col_ctr
  import sdram_col_pkg::*;
#(
  parameter int unsigned COL_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 rd_go_i,
  input  logic                 wr_go_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic [BL_CODE_W-1:0] bl_code_i,
  input  logic                 single_wr_i,
  output logic [COL_W-1:0]     cur_col_o,
  output logic [LEN_W-1:0]     left_o,
  output logic                 fetch_o,
  output logic                 wr_en_o,
  output logic [COL_W-1:0]     wr_addr_o
);
  logic is_rd_q;
  logic step;

  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] c,
                                                input logic [BL_CODE_W-1:0] code);
    logic [COL_W-1:0] mask;
    mask = COL_W'((1 << code) - 1);
    return (c & ~mask) | ((c + COL_W'(1)) & mask);
  endfunction

  assign step      = en_i && !rd_go_i && !wr_go_i && (left_o != '0);
  assign fetch_o   = step && is_rd_q;
  assign wr_en_o   = wr_go_i || (step && !is_rd_q);
  assign wr_addr_o = wr_go_i ? col_i : cur_col_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_col_o <= '0;
      left_o    <= '0;
      is_rd_q   <= 1'b0;
    end else if (en_i) begin
      if (rd_go_i) begin
        cur_col_o <= col_i;
        left_o    <= bl_words(bl_code_i);
        is_rd_q   <= 1'b1;
      end else if (wr_go_i) begin
        cur_col_o <= next_col(col_i, bl_code_i);
        left_o    <= single_wr_i ? '0 : bl_words(bl_code_i) - LEN_W'(1);
        is_rd_q   <= 1'b0;
      end else if (left_o != '0) begin
        cur_col_o <= next_col(cur_col_o, bl_code_i);
        left_o    <= left_o - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdram_col_array.sv
module sdram_col_array #(
  parameter int unsigned COL_W = 4,
  parameter int unsigned DQ_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [COL_W-1:0] waddr_i,
  input  logic [DQ_W-1:0]  wdata_i,
  input  logic [COL_W-1:0] raddr_i,
  output logic [DQ_W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << COL_W;

  logic [DQ_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[i] <= '0;
      else if (we_i && waddr_i == COL_W'(i))     mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sdram_col_rd_pipe.sv
module sdram_col_rd_pipe #(
  parameter int unsigned DQ_W    = 8,
  parameter int unsigned CAS_LAT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            fetch_i,
  input  logic [DQ_W-1:0] din_i,
  output logic [DQ_W-1:0] dout_o,
  output logic            vld_o,
  output logic            busy_o
);
  logic [DQ_W-1:0]    dat_q [CAS_LAT];
  logic [CAS_LAT-1:0] vld_q;

  // stage 0 holds the word fetched on the edge after the command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q[0] <= '0;
      vld_q[0] <= 1'b0;
    end else if (en_i) begin
      vld_q[0] <= fetch_i;
      if (fetch_i) dat_q[0] <= din_i;
    end
  end

  for (genvar s = 1; s < CAS_LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dat_q[s] <= '0;
        vld_q[s] <= 1'b0;
      end else if (en_i) begin
        vld_q[s] <= vld_q[s-1];
        if (vld_q[s-1]) dat_q[s] <= dat_q[s-1];
      end
    end
  end

  assign dout_o = dat_q[CAS_LAT-1];
  assign vld_o  = vld_q[CAS_LAT-1];
  assign busy_o = |vld_q;
endmodule

// File: rtl/sdram_col_engine.sv
module sdram_col_engine
  import sdram_col_pkg::*;
#(
  parameter int unsigned COL_W   = 4,
  parameter int unsigned DQ_W    = 8,
  parameter int unsigned CAS_LAT = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic [1:0]           cmd_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic [DQ_W-1:0]      wdata_i,
  input  logic [BL_CODE_W-1:0] bl_code_i,
  input  logic                 single_wr_i,
  output logic [DQ_W-1:0]      rdata_o,
  output logic                 rdata_vld_o
);
  logic             cke_q;
  logic             active;
  logic             en;
  logic             rd_go, wr_go;
  logic [COL_W-1:0] cur_col;
  logic [LEN_W-1:0] words_left;
  logic             fetch;
  logic             wr_en;
  logic [COL_W-1:0] wr_addr;
  logic [DQ_W-1:0]  arr_rdata;
  logic             pipe_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  // suspend applies only while a burst or read word is in flight
  assign active = (words_left != '0) || pipe_busy;
  assign en     = cke_q || !active;
  assign rd_go  = en && (cmd_i == CMD_READ);
  assign wr_go  = en && (cmd_i == CMD_WRITE);

  sdram_col_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .rd_go_i     (rd_go),
    .wr_go_i     (wr_go),
    .col_i       (col_i),
    .bl_code_i   (bl_code_i),
    .single_wr_i (single_wr_i),
    .cur_col_o   (cur_col),
    .left_o      (words_left),
    .fetch_o     (fetch),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr)
  );

  sdram_col_array #(.COL_W(COL_W), .DQ_W(DQ_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wdata_i),
    .raddr_i (cur_col),
    .rdata_o (arr_rdata)
  );

  sdram_col_rd_pipe #(.DQ_W(DQ_W), .CAS_LAT(CAS_LAT)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .fetch_i (fetch),
    .din_i   (arr_rdata),
    .dout_o  (rdata_o),
    .vld_o   (rdata_vld_o),
    .busy_o  (pipe_busy)
  );
endmodule

// File: rtl/sdram_col_engine_chk.sv
module sdram_col_engine_chk #(
  parameter int unsigned COL_W = 4,
  parameter int unsigned DQ_W  = 8,
  parameter int unsigned LEN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cke_i,
  input logic [1:0]       cmd_i,
  input logic             single_wr_i,
  input logic [DQ_W-1:0]  rdata_o,
  input logic             rdata_vld_o,
  input logic             en,
  input logic [COL_W-1:0] cur_col,
  input logic [LEN_W-1:0] words_left
);
  // R2: with the clock running, first word follows two edges after READ
  assert_cas_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && cmd_i == 2'b01 && cke_i) ##1 cke_i |=> ##1 rdata_vld_o);

  // R5: single-write mode leaves nothing left after the WRITE edge
  assert_single_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && cmd_i == 2'b10 && single_wr_i) |=> (words_left == '0));

  // R7: a suspended edge leaves the burst counter untouched
  assert_ctr_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> ($stable(cur_col) && $stable(words_left)));

  // R9: read output holds across a suspended edge
  assert_dq_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!cke_i) && rdata_vld_o) |=> ($stable(rdata_o) && rdata_vld_o));

  // R11: idle block ignores clock-enable
  assert_idle_runs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (words_left == '0 && !rdata_vld_o && $past(!cke_i) && cmd_i == 2'b00) |-> en);
endmodule

bind sdram_col_engine sdram_col_engine_chk #(
  .COL_W(COL_W), .DQ_W(DQ_W), .LEN_W(sdram_col_pkg::LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cke_i       (cke_i),
  .cmd_i       (cmd_i),
  .single_wr_i (single_wr_i),
  .rdata_o     (rdata_o),
  .rdata_vld_o (rdata_vld_o),
  .en          (en),
  .cur_col     (cur_col),
  .words_left  (words_left)
);

// File: tb/sdram_col_engine_tb.sv
module sdram_col_engine_tb;
  localparam int COL_W = 4;
  localparam int DQ_W  = 8;
  localparam int DEPTH = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cke = 1'b1;
  logic [1:0]       cmd = 2'b00;
  logic [COL_W-1:0] col = '0;
  logic [DQ_W-1:0]  wdata = '0;
  logic [1:0]       bl_code = 2'd0;
  logic             single_wr = 1'b0;
  logic [DQ_W-1:0]  rdata;
  logic             rvld;

  logic [DQ_W-1:0]  model [DEPTH];
  int n_chk = 0;
  int n_err = 0;
  logic prev_cke = 1'b1;

  always #2.5 clk = ~clk;

  sdram_col_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cmd_i(cmd), .col_i(col),
    .wdata_i(wdata), .bl_code_i(bl_code), .single_wr_i(single_wr),
    .rdata_o(rdata), .rdata_vld_o(rvld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [COL_W-1:0] nxt(input logic [COL_W-1:0] c, input logic [1:0] code);
    logic [COL_W-1:0] m;
    m = COL_W'((1 << code) - 1);
    return (c & ~m) | ((c + 1'b1) & m);
  endfunction

  function automatic logic [COL_W-1:0] addr_at(input logic [COL_W-1:0] s, input int j,
                                              input logic [1:0] code);
    logic [COL_W-1:0] a;
    a = s;
    for (int k = 0; k < j; k++) a = nxt(a, code);
    return a;
  endfunction

  function automatic logic rnd_cke(input int p_low);
    return ($urandom_range(99) < p_low) ? 1'b0 : 1'b1;
  endfunction

  task automatic edge_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int p_low);
    for (int i = 0; i < n; i++) begin
      cmd = 2'b00;
      cke = rnd_cke(p_low);
      prev_cke = cke;
      edge_step();
    end
  endtask

  task automatic run_read(input logic [COL_W-1:0] c, input int p_low, input string tag);
    int internal;
    int e;
    int bl;
    logic en;
    bl = 1 << bl_code;
    cmd = 2'b01; col = c; cke = rnd_cke(p_low); prev_cke = cke;
    edge_step();
    cmd = 2'b00;
    chk({tag, " R2 no early data"}, 32'(rvld), 32'd0);
    internal = 0; e = 0;
    while (internal < 2 + bl) begin
      en = prev_cke;
      e++;
      cke = (e > 30) ? 1'b1 : rnd_cke(p_low);
      prev_cke = cke;
      if (!en) begin
        cmd = 2'b10; col = COL_W'($urandom); wdata = DQ_W'($urandom);  // R8 junk
      end else begin
        cmd = 2'b00;
      end
      edge_step();
      cmd = 2'b00;
      if (en) internal++;
      if (internal >= 2 && internal < 2 + bl) begin
        chk({tag, " R9 R10 vld"}, 32'(rvld), 32'd1);
        chk({tag, " R3 data"}, 32'(rdata), 32'(model[addr_at(c, internal - 2, bl_code)]));
      end else begin
        chk({tag, " R2 vld low"}, 32'(rvld), 32'd0);
      end
    end
  endtask

  task automatic run_write(input logic [COL_W-1:0] c, input int p_low);
    int internal;
    int e;
    int blw;
    logic en;
    blw = single_wr ? 1 : (1 << bl_code);
    cmd = 2'b10; col = c; wdata = DQ_W'($urandom); cke = rnd_cke(p_low); prev_cke = cke;
    model[c] = wdata;
    edge_step();
    cmd = 2'b00;
    internal = 0; e = 0;
    while (internal < blw - 1) begin
      en = prev_cke;
      e++;
      cke = (e > 30) ? 1'b1 : rnd_cke(p_low);
      prev_cke = cke;
      wdata = DQ_W'($urandom);
      if (!en) begin
        cmd = 2'b01; col = COL_W'($urandom);  // R8 ignored read
      end else begin
        cmd = 2'b00;
      end
      if (en) model[addr_at(c, internal + 1, bl_code)] = wdata;
      edge_step();
      cmd = 2'b00;
      if (en) internal++;
    end
  endtask

  task automatic readback(input string tag);
    logic [1:0] saved;
    saved = bl_code;
    bl_code = 2'd3;
    run_read('0, 0, tag);
    run_read(COL_W'(8), 0, tag);
    bl_code = saved;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 vld at reset", 32'(rvld), 32'd0);
    rst_n = 1'b1;
    edge_step();
    chk("R1 vld after reset", 32'(rvld), 32'd0);
    readback("R1");

    // directed: every burst length, clock running
    for (int b = 0; b < 4; b++) begin
      bl_code = 2'(b);
      run_write(COL_W'(5 + b), 0);
      readback("R4");
      run_read(COL_W'(6), 0, "R2 R3");
      idle(2, 0);
    end

    // directed: suspend inside CAS window, fixed pattern
    bl_code = 2'd2;
    cmd = 2'b01; col = COL_W'(3); cke = 1'b0; prev_cke = 1'b0;
    edge_step();                        // READ edge, cke low -> edge1 suspended
    cmd = 2'b00; cke = 1'b1; edge_step();  // edge1 suspended
    chk("R10 no fetch yet", 32'(rvld), 32'd0);
    edge_step();                        // edge2: fetch
    chk("R10 still latency", 32'(rvld), 32'd0);
    edge_step();                        // edge3: word0
    chk("R10 delayed first word", 32'(rvld), 32'd1);
    chk("R10 word0 data", 32'(rdata), 32'(model[3]));
    cke = 1'b0; edge_step();            // edge4: word1, samples low
    cke = 1'b1; edge_step();            // edge5 suspended
    chk("R9 held vld", 32'(rvld), 32'd1);
    chk("R9 held data", 32'(rdata), 32'(model[addr_at(3, 1, 2'd2)]));
    idle(5, 0);
    chk("R2 burst done", 32'(rvld), 32'd0);
    prev_cke = 1'b1;

    // single-write mode
    single_wr = 1'b1;
    bl_code = 2'd3;
    run_write(COL_W'(2), 0);
    readback("R5");
    run_read(COL_W'(2), 0, "R6");
    run_write(COL_W'(12), 40);
    readback("R5");
    single_wr = 1'b0;

    // idle clock-enable low is ignored
    idle(3, 100);
    bl_code = 2'd1;
    run_read(COL_W'(9), 0, "R11");
    idle(3, 100);
    run_write(COL_W'(14), 0);
    readback("R11");

    // constrained random with suspend
    for (int it = 0; it < 40; it++) begin
      bl_code = 2'($urandom_range(3));
      single_wr = ($urandom_range(3) == 0);
      run_write(COL_W'($urandom), 35);
      idle($urandom_range(2), 50);
      run_read(COL_W'($urandom), 35, single_wr ? "R6 R7" : "R7");
      idle($urandom_range(2), 50);
      if (it % 8 == 7) readback("R8");
    end
    single_wr = 1'b0;
    readback("R8");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule